// File: doc/BRIEF.md
# Sixteen-Bit Ripple-Carry Bit-Slice ALU

This block is a combinational arithmetic/logic unit made of identical one-bit slices. Each slice receives one bit of the X operand, one bit of the Y operand and a carry input. It produces one result bit and one carry output. The carry output of each slice feeds the carry input of the slice above it. The lowest slice's carry input is tied to zero.

Six shared control bits drive every slice in the same way:
- Operand X can be cleared, then inverted.
- Operand Y can be cleared, then inverted.
- Either a full-adder sum or a bitwise AND is selected.
- The selected bit can be inverted on its way out.

The top level also provides two status flags:
- A zero flag, high when the whole result word is zero.
- A negative flag, equal to the most significant result bit.

X normally comes from the data register and Y from the address register or from memory. The result word is returned to the data-register input.

Top module: `bitslice_alu`

## Requirements
- R1: When `clr_x`=1, the X operand is taken as zero before the inversion stage. With `clr_x`=1 and `neg_x`=1, X is all ones.
- R2: When `clr_y`=1, the Y operand is taken as zero before the inversion stage. With `clr_y`=1 and `neg_y`=1, Y is all ones.
- R3: `neg_x` and `neg_y` each invert every bit of the conditioned operand they govern.
- R4: With `add_sel`=1 and `neg_out`=0, `result` equals the conditioned X plus the conditioned Y, modulo 2^16, with a carry input of zero at bit 0.
- R5: With `add_sel`=0 and `neg_out`=0, `result` equals the bitwise AND of the conditioned X and Y.
- R6: `neg_out`=1 inverts every bit of the selected result. It has no effect on `carry_out`.
- R7: `carry_out` is the carry out of bit 15 of the addition when `add_sel`=1, and 0 when `add_sel`=0.
- R8: `zr` is 1 exactly when all 16 bits of `result` are 0.
- R9: `ng` equals bit 15 of `result`.
- R10: The block holds no state. Outputs follow a change of inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | 16 | X operand (data register) |
| y_in | input | 16 | Y operand (address register or memory) |
| clr_x | input | 1 | Clear X before inversion |
| neg_x | input | 1 | Invert conditioned X |
| clr_y | input | 1 | Clear Y before inversion |
| neg_y | input | 1 | Invert conditioned Y |
| add_sel | input | 1 | 1: add, 0: bitwise AND |
| neg_out | input | 1 | Invert the result word |
| result | output | 16 | Result word to data-register input |
| carry_out | output | 1 | Carry from the top slice |
| zr | output | 1 | Result-is-zero flag |
| ng | output | 1 | Result sign flag |

## Verification
The assertions are immediate checks that are evaluated whenever the inputs settle. They assume that every operand and control bit is a known 0 or 1. Each check is skipped while any input is still unknown, so the state before the first stimulus raises nothing. The bench drives only fully defined values: walking all 64 control combinations over random operand pairs, followed by directed corners (all-ones operands, overflow, zero results). Every input is changed away from the sampling point, so each comparison sees settled combinational outputs.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;
  localparam int unsigned SLICES = 16;

  // Clear first, then invert: (b & ~clr) ^ inv
  function automatic logic cond_bit(input logic b, input logic clr, input logic inv);
    return (b & ~clr) ^ inv;
  endfunction

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/operand_cond.sv
module operand_cond
  import bitslice_alu_pkg::*;
(
  input  logic bit_i,
  input  logic clr_i,
  input  logic inv_i,
  output logic bit_o
);
  always_comb bit_o = cond_bit(bit_i, clr_i, inv_i);
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import bitslice_alu_pkg::*;
(
  input  logic xb_i,
  input  logic yb_i,
  input  logic cin_i,
  input  logic clr_x,
  input  logic neg_x,
  input  logic clr_y,
  input  logic neg_y,
  input  logic add_sel,
  input  logic neg_out,
  output logic rb_o,
  output logic cout_o
);
  logic xc, yc, sel_bit;

  operand_cond u_cx (.bit_i(xb_i), .clr_i(clr_x), .inv_i(neg_x), .bit_o(xc));
  operand_cond u_cy (.bit_i(yb_i), .clr_i(clr_y), .inv_i(neg_y), .bit_o(yc));

  always_comb begin
    sel_bit = add_sel ? fa_sum(xc, yc, cin_i) : (xc & yc);
    rb_o    = sel_bit ^ neg_out;
    // Carry is taken before output inversion and held low in logic mode
    cout_o  = add_sel & fa_carry(xc, yc, cin_i);
  end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] word_i,
  output logic         zero_o,
  output logic         sign_o
);
  always_comb begin
    zero_o = ~|word_i;
    sign_o = word_i[W-1];
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import bitslice_alu_pkg::*;
#(
  parameter int unsigned WIDTH = SLICES
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic             clr_x,
  input  logic             neg_x,
  input  logic             clr_y,
  input  logic             neg_y,
  input  logic             add_sel,
  input  logic             neg_out,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zr,
  output logic             ng
);
  localparam int unsigned CW = WIDTH + 1;

  // carry_chain[i] feeds slice i; carry_chain[WIDTH] leaves the top slice
  logic [CW-1:0] carry_chain;
  assign carry_chain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .xb_i   (x_in[i]),
      .yb_i   (y_in[i]),
      .cin_i  (carry_chain[i]),
      .clr_x  (clr_x),
      .neg_x  (neg_x),
      .clr_y  (clr_y),
      .neg_y  (neg_y),
      .add_sel(add_sel),
      .neg_out(neg_out),
      .rb_o   (result[i]),
      .cout_o (carry_chain[i+1])
    );
  end

  assign carry_out = carry_chain[WIDTH];

  alu_status #(.W(WIDTH)) u_status (
    .word_i(result),
    .zero_o(zr),
    .sign_o(ng)
  );
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] x_in,
  input logic [WIDTH-1:0] y_in,
  input logic             clr_x,
  input logic             neg_x,
  input logic             clr_y,
  input logic             neg_y,
  input logic             add_sel,
  input logic             neg_out,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             zr,
  input logic             ng,
  input logic [WIDTH:0]   carry_chain
);
  logic known;
  always_comb known = !$isunknown({x_in, y_in, clr_x, neg_x, clr_y, neg_y, add_sel, neg_out});

  always_comb begin
    if (known) begin
      // R7: logic mode never ripples
      p_and_no_ripple_r7: assert (add_sel || carry_chain == '0);
      // R7: exported carry is the top of the chain, and bit 0 has no carry in
      p_carry_top_r7: assert (carry_out == carry_chain[WIDTH] && carry_chain[0] == 1'b0);
      // R5: plain AND with raw operands cannot set a bit absent from X
      p_and_subset_r5: assert (add_sel || neg_out || clr_x || neg_x || clr_y || neg_y
                               || (result & ~x_in) == '0);
      // R1: cleared-and-inverted X in AND mode passes conditioned Y through
      p_clear_then_invert_r1: assert (add_sel || !clr_x || !neg_x || neg_out || clr_y || neg_y
                                      || result == y_in);
      // R8: zero flag agrees with the result word
      p_zero_flag_r8: assert (zr == (result == '0));
      // R9: sign flag tracks the top result bit
      p_sign_flag_r9: assert (ng == result[WIDTH-1]);
    end
  end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .x_in(x_in), .y_in(y_in), .clr_x(clr_x), .neg_x(neg_x), .clr_y(clr_y),
  .neg_y(neg_y), .add_sel(add_sel), .neg_out(neg_out), .result(result),
  .carry_out(carry_out), .zr(zr), .ng(ng), .carry_chain(carry_chain)
);

// File: tb/tb_bitslice_alu.sv
`timescale 1ns/1ps
module tb_bitslice_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] x_in, y_in, result;
  logic clr_x, neg_x, clr_y, neg_y, add_sel, neg_out;
  logic carry_out, zr, ng;

  bitslice_alu dut (
    .x_in(x_in), .y_in(y_in), .clr_x(clr_x), .neg_x(neg_x), .clr_y(clr_y),
    .neg_y(neg_y), .add_sel(add_sel), .neg_out(neg_out), .result(result),
    .carry_out(carry_out), .zr(zr), .ng(ng)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference
  int exp_r, exp_c;
  task automatic model(input int ctl, input int xv, input int yv);
    int a, b, s;
    a = (ctl & 32) ? 0 : xv;
    if (ctl & 16) a = a ^ 16'hFFFF;
    b = (ctl & 8) ? 0 : yv;
    if (ctl & 4) b = b ^ 16'hFFFF;
    if (ctl & 2) begin
      s = a + b;
      exp_r = s % 65536;
      exp_c = s / 65536;
    end else begin
      exp_r = a & b;
      exp_c = 0;
    end
    if (ctl & 1) exp_r = exp_r ^ 16'hFFFF;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ctl bits: 5 clr_x, 4 neg_x, 3 clr_y, 2 neg_y, 1 add_sel, 0 neg_out
  task automatic apply_and_check(input int ctl, input logic [15:0] xv, input logic [15:0] yv,
                                 input string tag);
    @(posedge clk);
    {clr_x, neg_x, clr_y, neg_y, add_sel, neg_out} = ctl[5:0];
    x_in = xv; y_in = yv;
    @(negedge clk);
    model(ctl, int'(xv), int'(yv));
    chk(tag, int'(result), exp_r);
    chk("R7 carry", int'(carry_out), exp_c);
    chk("R8 zr", int'(zr), (exp_r == 0) ? 1 : 0);
    chk("R9 ng", int'(ng), (exp_r >> 15) & 1);
  endtask

  initial begin
    x_in = '0; y_in = '0;
    {clr_x, neg_x, clr_y, neg_y, add_sel, neg_out} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset/idle state: AND of zeros
    chk("R5 idle result", int'(result), 0);
    chk("R8 idle zr", int'(zr), 1);

    // Exhaustive control sweep over random operands
    for (int ctl = 0; ctl < 64; ctl++) begin
      for (int n = 0; n < 30; n++) begin
        apply_and_check(ctl, 16'($urandom), 16'($urandom),
                        (ctl & 2) ? "R4/R6 add path" : "R5/R6 and path");
      end
    end

    // Directed corners
    apply_and_check(6'b100000, 16'h1234, 16'hABCD, "R1 clr_x and");
    apply_and_check(6'b110000, 16'h1234, 16'hABCD, "R1 clr_x then neg_x");
    apply_and_check(6'b000010, 16'h5555, 16'h5555, "R2 baseline add");
    apply_and_check(6'b001110, 16'h0007, 16'h0000, "R2 clr_y then neg_y: x-1");
    apply_and_check(6'b010010, 16'h00FF, 16'h0001, "R3 neg_x add");
    apply_and_check(6'b000110, 16'h0003, 16'h0001, "R3 neg_y add");
    apply_and_check(6'b000010, 16'hFFFF, 16'h0001, "R4 wrap to zero");
    apply_and_check(6'b000010, 16'h8000, 16'h8000, "R4 overflow carry");
    apply_and_check(6'b000010, 16'h7FFF, 16'h0001, "R4 full ripple");
    apply_and_check(6'b000000, 16'hFFFF, 16'hFFFF, "R5 and ones");
    apply_and_check(6'b000011, 16'hFFFF, 16'h0001, "R6 inv out keeps carry");
    apply_and_check(6'b000001, 16'h0000, 16'h0000, "R6 inv out of zero");

    // R10: no clock needed between input change and output
    @(posedge clk);
    #2;
    {clr_x, neg_x, clr_y, neg_y, add_sel, neg_out} = 6'b000010;
    x_in = 16'd100; y_in = 16'd23;
    #1;
    chk("R10 comb add", int'(result), 123);
    x_in = 16'd0; y_in = 16'd0;
    #1;
    chk("R10 comb zero", int'(zr), 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule